// File: doc/BRIEF.md
# DIP-2 Status Sync Monitor

This block watches the received flow-control status path of a packet interface. Status arrives as a stream of 2-bit words, one per calendar slot. Each calendar sequence is closed by a DIP-2 parity word. The block keeps a running 2-bit XOR of every status word in the current sequence and compares it with the parity word. Each comparison counts as one good or one bad parity event. Consecutive good and bad events are counted against two programmable thresholds, and a two-state machine moves between out-of-sync and in-sync.

The status words are passed downstream one cycle later, together with their slot index within the sequence. They are sanitized on the way:
- While the path is out of sync, every slot reports satisfied, so nothing is sent to ports whose status has not been verified.
- In bypass mode there is no parity checking. The path is held in sync and every slot reports starving.

Top module: `dip2_sync_monitor`

## Requirements
- R1: After reset, `inSync`, `dipErr` and `statusOutValid` are all low.
- R2: A word with `wordIsDip` high is compared with the XOR of all status words received since the previous parity word (or since reset). A mismatch raises `dipErr` for exactly one cycle, on the cycle after the parity word, in either sync state.
- R3: While out of sync, the block enters in-sync on the `cfgInsyncThr`-th consecutive good parity event. A threshold of 0 acts as 1. A bad event restarts the count.
- R4: While in sync, the block drops to out-of-sync on the `cfgOutsyncThr`-th consecutive bad parity event. A threshold of 0 acts as 1. A good event clears the bad count.
- R5: While in sync and not in bypass, each status word appears unchanged on `statusOut` one cycle after it is received, with `statusOutValid` high. `statusSlot` counts 0, 1, 2 … from the first word after a parity word, and saturates at `MAX_SLOTS-1`.
- R6: While out of sync (and not in bypass), every reported status is satisfied (2'b10). The encodings are: 2'b00 starving, 2'b01 hungry, 2'b10 satisfied.
- R7: While `cfgNoStatus` is high, `inSync` is high from the next cycle on, parity words never raise `dipErr`, and the good and bad counts are cleared. After `cfgNoStatus` is released, the block stays in sync.
- R8: While `cfgNoStatus` is high, every reported status is starving (2'b00).
- R9: `inSync` changes only on the cycle after a parity word, or when bypass mode forces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wordValid | input | 1 | A status or parity word is present this cycle |
| wordIsDip | input | 1 | The present word is the DIP-2 word that closes the sequence |
| statusWord | input | 2 | Received 2-bit word |
| cfgInsyncThr | input | 5 | Consecutive good events needed to acquire sync |
| cfgOutsyncThr | input | 4 | Consecutive bad events needed to lose sync |
| cfgNoStatus | input | 1 | Bypass: no checking, forced in-sync, starving status |
| inSync | output | 1 | Sync state (1 = in sync) |
| dipErr | output | 1 | One-cycle pulse per parity mismatch |
| statusOutValid | output | 1 | Sanitized status word valid |
| statusOut | output | 2 | Sanitized status word |
| statusSlot | output | SLOT_W | Slot index of the reported word in its sequence |

## Verification
The error pulse and a sync-state change can land on the same cycle. This happens when the bad parity word that reaches the loss threshold raises `dipErr` and also drops `inSync`. The bench provokes it with runs of corrupted parity words under a small threshold and under the 15 setting. On the cycle after each parity word, it compares both outputs against a model that tracks the state and the counts. The same run checks that the status words reported before the drop still pass through unchanged, and that those reported after it are forced to satisfied.

// File: rtl/dip2_mon_pkg.sv
package dip2_mon_pkg;

  localparam int STAT_W = 2;

  localparam logic [STAT_W-1:0] STAT_STARVING  = 2'b00;
  localparam logic [STAT_W-1:0] STAT_HUNGRY    = 2'b01;
  localparam logic [STAT_W-1:0] STAT_SATISFIED = 2'b10;

  typedef enum logic {
    SYNC_OUT = 1'b0,
    SYNC_IN  = 1'b1
  } syncState_t;

  // parity outcome of one sequence, datapath -> control
  typedef struct packed {
    logic good;
    logic bad;
  } dipEvt_t;

  // strobes, control -> datapath
  typedef struct packed {
    logic checkEn;
    logic forceSat;
    logic forceStarve;
  } ctrlStrb_t;

endpackage

// File: rtl/dip2_datapath.sv
module dip2_datapath
  import dip2_mon_pkg::*;
#(
  parameter int MAX_SLOTS = 256,
  parameter int SLOT_W    = $clog2(MAX_SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordValid,
  input  logic              wordIsDip,
  input  logic [STAT_W-1:0] statusWord,
  input  ctrlStrb_t         ctrl,
  output dipEvt_t           evt,
  output logic              statusOutValid,
  output logic [STAT_W-1:0] statusOut,
  output logic [SLOT_W-1:0] statusSlot
);

  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(MAX_SLOTS - 1);

  logic [STAT_W-1:0] parityAcc;
  logic [SLOT_W-1:0] slotCnt;
  logic              dipSeen;
  logic              statSeen;
  logic              parityMatch;
  logic [STAT_W-1:0] cleanStat;

  assign dipSeen     = wordValid &&  wordIsDip;
  assign statSeen    = wordValid && !wordIsDip;
  assign parityMatch = (parityAcc == statusWord);

  always_comb begin
    evt.good = dipSeen && ctrl.checkEn &&  parityMatch;
    evt.bad  = dipSeen && ctrl.checkEn && !parityMatch;
  end

  // starving in bypass wins over satisfied
  always_comb begin
    if (ctrl.forceStarve)   cleanStat = STAT_STARVING;
    else if (ctrl.forceSat) cleanStat = STAT_SATISFIED;
    else                    cleanStat = statusWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      parityAcc <= '0;
      slotCnt   <= '0;
    end else if (dipSeen) begin
      parityAcc <= '0;
      slotCnt   <= '0;
    end else if (statSeen) begin
      parityAcc <= parityAcc ^ statusWord;
      if (slotCnt != SLOT_LAST) slotCnt <= slotCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusOutValid <= 1'b0;
      statusOut      <= STAT_STARVING;
      statusSlot     <= '0;
    end else begin
      statusOutValid <= statSeen;
      if (statSeen) begin
        statusOut  <= cleanStat;
        statusSlot <= slotCnt;
      end
    end
  end

endmodule

// File: rtl/dip2_control.sv
module dip2_control
  import dip2_mon_pkg::*;
#(
  parameter int IN_THR_W  = 5,
  parameter int OUT_THR_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dipEvt_t              evt,
  input  logic [IN_THR_W-1:0]  cfgInsyncThr,
  input  logic [OUT_THR_W-1:0] cfgOutsyncThr,
  input  logic                 cfgNoStatus,
  output ctrlStrb_t            ctrl,
  output logic                 inSync,
  output logic                 dipErr
);

  syncState_t             state;
  logic [IN_THR_W-1:0]    goodCnt;
  logic [OUT_THR_W-1:0]   badCnt;
  logic [IN_THR_W:0]      goodNext;
  logic [OUT_THR_W:0]     badNext;
  logic [IN_THR_W:0]      inThrEff;
  logic [OUT_THR_W:0]     outThrEff;

  always_comb begin
    goodNext  = {1'b0, goodCnt} + {{IN_THR_W{1'b0}}, 1'b1};
    badNext   = {1'b0, badCnt} + {{OUT_THR_W{1'b0}}, 1'b1};
    inThrEff  = (cfgInsyncThr == '0)  ? {{IN_THR_W{1'b0}}, 1'b1}  : {1'b0, cfgInsyncThr};
    outThrEff = (cfgOutsyncThr == '0) ? {{OUT_THR_W{1'b0}}, 1'b1} : {1'b0, cfgOutsyncThr};
  end

  always_comb begin
    ctrl.checkEn     = !cfgNoStatus;
    ctrl.forceStarve = cfgNoStatus;
    ctrl.forceSat    = (state == SYNC_OUT);
  end

  assign inSync = (state == SYNC_IN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= SYNC_OUT;
      goodCnt <= '0;
      badCnt  <= '0;
      dipErr  <= 1'b0;
    end else begin
      dipErr <= evt.bad;
      if (cfgNoStatus) begin
        state   <= SYNC_IN;
        goodCnt <= '0;
        badCnt  <= '0;
      end else if (state == SYNC_OUT) begin
        badCnt <= '0;
        if (evt.good) begin
          if (goodNext >= inThrEff) begin
            state   <= SYNC_IN;
            goodCnt <= '0;
          end else begin
            goodCnt <= goodNext[IN_THR_W-1:0];
          end
        end else if (evt.bad) begin
          goodCnt <= '0;
        end
      end else begin
        goodCnt <= '0;
        if (evt.bad) begin
          if (badNext >= outThrEff) begin
            state  <= SYNC_OUT;
            badCnt <= '0;
          end else begin
            badCnt <= badNext[OUT_THR_W-1:0];
          end
        end else if (evt.good) begin
          badCnt <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/dip2_sync_monitor.sv
module dip2_sync_monitor
  import dip2_mon_pkg::*;
#(
  parameter int MAX_SLOTS = 256,
  parameter int IN_THR_W  = 5,
  parameter int OUT_THR_W = 4,
  parameter int SLOT_W    = $clog2(MAX_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wordValid,
  input  logic                 wordIsDip,
  input  logic [1:0]           statusWord,
  input  logic [IN_THR_W-1:0]  cfgInsyncThr,
  input  logic [OUT_THR_W-1:0] cfgOutsyncThr,
  input  logic                 cfgNoStatus,
  output logic                 inSync,
  output logic                 dipErr,
  output logic                 statusOutValid,
  output logic [1:0]           statusOut,
  output logic [SLOT_W-1:0]    statusSlot
);

  dipEvt_t   evt;
  ctrlStrb_t ctrl;

  dip2_datapath #(
    .MAX_SLOTS(MAX_SLOTS),
    .SLOT_W   (SLOT_W)
  ) u_datapath (
    .clk           (clk),
    .rstN          (rstN),
    .wordValid     (wordValid),
    .wordIsDip     (wordIsDip),
    .statusWord    (statusWord),
    .ctrl          (ctrl),
    .evt           (evt),
    .statusOutValid(statusOutValid),
    .statusOut     (statusOut),
    .statusSlot    (statusSlot)
  );

  dip2_control #(
    .IN_THR_W (IN_THR_W),
    .OUT_THR_W(OUT_THR_W)
  ) u_control (
    .clk          (clk),
    .rstN         (rstN),
    .evt          (evt),
    .cfgInsyncThr (cfgInsyncThr),
    .cfgOutsyncThr(cfgOutsyncThr),
    .cfgNoStatus  (cfgNoStatus),
    .ctrl         (ctrl),
    .inSync       (inSync),
    .dipErr       (dipErr)
  );

endmodule

// File: rtl/dip2_sync_checker.sv
module dip2_sync_checker (
  input logic       clk,
  input logic       rstN,
  input logic       wordValid,
  input logic       wordIsDip,
  input logic [1:0] statusWord,
  input logic       cfgNoStatus,
  input logic       inSync,
  input logic       dipErr,
  input logic       statusOutValid,
  input logic [1:0] statusOut
);

  AST_ERR_NEEDS_DIP: assert property (@(posedge clk) disable iff (!rstN)
    dipErr |-> $past(wordValid && wordIsDip && !cfgNoStatus)); // R2

  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    dipErr && !$past(wordValid && wordIsDip) |-> 1'b0); // R2

  AST_PASS_IN_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    statusOutValid && $past(inSync) && !$past(cfgNoStatus)
      |-> statusOut == $past(statusWord)); // R5

  AST_OOS_SATISFIED: assert property (@(posedge clk) disable iff (!rstN)
    statusOutValid && !$past(inSync) && !$past(cfgNoStatus)
      |-> statusOut == 2'b10); // R6

  AST_BYPASS_IN_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    cfgNoStatus |=> inSync && !dipErr); // R7

  AST_BYPASS_STARVING: assert property (@(posedge clk) disable iff (!rstN)
    statusOutValid && $past(cfgNoStatus) |-> statusOut == 2'b00); // R8

  AST_STATE_AT_DIP: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(inSync) |-> $past(wordValid && wordIsDip) || $past(cfgNoStatus)); // R9

endmodule

bind dip2_sync_monitor dip2_sync_checker u_checker (
  .clk           (clk),
  .rstN          (rstN),
  .wordValid     (wordValid),
  .wordIsDip     (wordIsDip),
  .statusWord    (statusWord),
  .cfgNoStatus   (cfgNoStatus),
  .inSync        (inSync),
  .dipErr        (dipErr),
  .statusOutValid(statusOutValid),
  .statusOut     (statusOut)
);

// File: tb/dip2_sync_monitor_bench.sv
`timescale 1ns/1ps
module dip2_sync_monitor_bench;

  localparam int MAX_SLOTS = 256;
  localparam int SLOT_W    = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wordValid = 1'b0;
  logic              wordIsDip = 1'b0;
  logic [1:0]        statusWord = 2'b00;
  logic [4:0]        cfgInsyncThr = 5'd31;
  logic [3:0]        cfgOutsyncThr = 4'd15;
  logic              cfgNoStatus = 1'b0;
  logic              inSync;
  logic              dipErr;
  logic              statusOutValid;
  logic [1:0]        statusOut;
  logic [SLOT_W-1:0] statusSlot;

  always #2.5 clk = ~clk;

  dip2_sync_monitor u_dip2_sync_monitor (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordIsDip(wordIsDip),
    .statusWord(statusWord), .cfgInsyncThr(cfgInsyncThr),
    .cfgOutsyncThr(cfgOutsyncThr), .cfgNoStatus(cfgNoStatus),
    .inSync(inSync), .dipErr(dipErr), .statusOutValid(statusOutValid),
    .statusOut(statusOut), .statusSlot(statusSlot)
  );

  int    nChecks = 0;
  int    nFails  = 0;
  bit    finished = 1'b0;

  // scoreboard queues
  logic [1:0] expValQ[$];
  int         expSlotQ[$];
  string      expTagQ[$];

  // reference model
  bit         mIn = 1'b0;
  int         mGood = 0;
  int         mBad = 0;
  logic [1:0] mAcc = 2'b00;
  int         mSlot = 0;
  logic [7:0] lfsr = 8'hA5;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [1:0] nextWord();
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    return lfsr[1:0];
  endfunction

  task automatic sendWord(input logic [1:0] w, input bit isDip, input string tag);
    bit expErr;
    int inThr;
    int outThr;
    expErr = 1'b0;
    wordValid  = 1'b1;
    wordIsDip  = isDip;
    statusWord = w;
    if (!isDip) begin
      expValQ.push_back(cfgNoStatus ? 2'b00 : (!mIn ? 2'b10 : w));
      expSlotQ.push_back(mSlot);
      expTagQ.push_back(cfgNoStatus ? "R8" : (!mIn ? "R6" : "R5"));
      mAcc = mAcc ^ w;
      if (mSlot < MAX_SLOTS - 1) mSlot++;
    end else begin
      inThr  = (cfgInsyncThr == 0) ? 1 : int'(cfgInsyncThr);
      outThr = (cfgOutsyncThr == 0) ? 1 : int'(cfgOutsyncThr);
      if (cfgNoStatus) begin
        mIn = 1'b1; mGood = 0; mBad = 0;
      end else begin
        expErr = (mAcc != w);
        if (!mIn) begin
          if (!expErr) begin
            mGood++;
            if (mGood >= inThr) begin mIn = 1'b1; mGood = 0; end
          end else mGood = 0;
        end else begin
          if (expErr) begin
            mBad++;
            if (mBad >= outThr) begin mIn = 1'b0; mBad = 0; end
          end else mBad = 0;
        end
      end
      mAcc  = 2'b00;
      mSlot = 0;
    end
    @(negedge clk);
    if (isDip) begin
      check(dipErr == expErr, "R2", "dipErr after parity word", int'(dipErr), int'(expErr));
      check(inSync == mIn, tag, "inSync after parity word", int'(inSync), int'(mIn));
    end
  endtask

  task automatic sendSeq(input int len, input bit corrupt, input string tag);
    for (int i = 0; i < len; i++) sendWord(nextWord(), 1'b0, tag);
    sendWord(mAcc ^ (corrupt ? 2'b01 : 2'b00), 1'b1, tag);
  endtask

  task automatic idle(input int n);
    wordValid = 1'b0;
    wordIsDip = 1'b0;
    repeat (n) @(negedge clk);
    check(dipErr == 1'b0, "R2", "dipErr pulse width", int'(dipErr), 0);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN && statusOutValid && !finished) begin
      if (expValQ.size() == 0) begin
        check(1'b0, "R5", "unexpected status output", 1, 0);
      end else begin
        logic [1:0] ev;
        int         es;
        string      et;
        ev = expValQ.pop_front();
        es = expSlotQ.pop_front();
        et = expTagQ.pop_front();
        check(statusOut == ev, et, "statusOut", int'(statusOut), int'(ev));
        check(int'(statusSlot) == es, "R5", "statusSlot", int'(statusSlot), es);
      end
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired: actual=1 expected=0");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(inSync == 1'b0, "R1", "inSync in reset", int'(inSync), 0);
    check(dipErr == 1'b0, "R1", "dipErr in reset", int'(dipErr), 0);
    check(statusOutValid == 1'b0, "R1", "statusOutValid in reset", int'(statusOutValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(inSync == 1'b0, "R1", "inSync after reset", int'(inSync), 0);

    // R3 acquisition with threshold 3, a bad word restarts the count
    cfgInsyncThr = 5'd3;
    cfgOutsyncThr = 4'd2;
    sendSeq(4, 1'b0, "R3");
    sendSeq(3, 1'b0, "R3");
    sendSeq(5, 1'b1, "R3");
    sendSeq(2, 1'b0, "R3");
    sendSeq(2, 1'b0, "R3");
    sendSeq(6, 1'b0, "R3");
    idle(2);

    // R5 pass-through of all encodings in sync
    sendWord(2'b00, 1'b0, "R5");
    sendWord(2'b01, 1'b0, "R5");
    sendWord(2'b10, 1'b0, "R5");
    sendWord(2'b11, 1'b0, "R5");
    sendWord(mAcc, 1'b1, "R5");
    sendSeq(9, 1'b0, "R5");

    // R4 loss: isolated bad words do not drop sync, two in a row do
    sendSeq(3, 1'b1, "R4");
    sendSeq(3, 1'b0, "R4");
    sendSeq(3, 1'b1, "R4");
    sendSeq(3, 1'b1, "R4");
    sendSeq(4, 1'b0, "R6");
    idle(3);

    // R3 zero threshold acts as one
    cfgInsyncThr = 5'd0;
    sendSeq(2, 1'b0, "R3");
    cfgOutsyncThr = 4'd0;
    sendSeq(2, 1'b1, "R4");

    // R7/R8 bypass: bad parity ignored, starving, sync held after exit
    cfgNoStatus = 1'b1;
    @(negedge clk);
    check(inSync == 1'b1, "R7", "inSync in bypass", int'(inSync), 1);
    sendSeq(4, 1'b1, "R7");
    sendSeq(3, 1'b1, "R8");
    cfgNoStatus = 1'b0;
    sendSeq(3, 1'b0, "R7");

    // R4 and R3 with the 15/31 settings
    cfgInsyncThr = 5'd31;
    cfgOutsyncThr = 4'd15;
    for (int k = 0; k < 15; k++) sendSeq(2, 1'b1, "R4");
    for (int k = 0; k < 31; k++) sendSeq(1, 1'b0, "R3");
    sendSeq(MAX_SLOTS + 3, 1'b0, "R5");
    idle(4);
    check(expValQ.size() == 0, "R5", "pending scoreboard items", expValQ.size(), 0);
    finish();
  end

endmodule